// File: doc/BRIEF.md
# SPI Burst Exchange Master

This block is a byte-wide SPI master that moves data in bursts. Software first empties the FIFOs if needed. It then writes a burst length and a count of bytes to take from the transmit FIFO, pushes the outgoing bytes, and sets a self-clearing start bit in the transfer control word. The engine shifts out the whole burst MSB first and samples one incoming byte for each byte sent. It stores each received byte in an on-chip receive FIFO. Software learns that the burst is complete when the receive level in the status word equals the burst length, or when the start bit reads back as zero.

The shift clock rate comes from outside the block. An enable input, `sclk_tick`, marks each half period of SCLK. One tick toggles SCLK once, so a byte takes sixteen ticks. The CPOL and CPHA control bits select one of the four standard SPI modes. Four chip-select lines are available. The selected line is driven automatically for the length of a burst, or, in manual mode, it follows a level bit that software writes. A polarity bit chooses whether the lines are active low or active high.

The register port is a plain strobe interface. Reads are combinational and writes take effect at the clock edge. Register map by `reg_addr`: 0 is transfer control, 1 is FIFO control, 2 is FIFO status, 3 is burst length, 4 is transmit count, and 5 is data (a write pushes to the transmit FIFO, a read with `reg_rd` pops the receive FIFO).

Top module: `spi_burst_master`

## Requirements
- R1: After reset, transfer control reads 0x0000_0004 (active-low select, mode 0, automatic select, index 0), FIFO status reads 0, SCLK is 0 and all four select lines are high.
- R2: Writing transfer control with bit 31 set and a non-zero burst length starts a burst. Bit 31 reads 1 while the burst runs and 0 once its last bit has been shifted. Each byte goes out MSB first as eight SCLK cycles.
- R3: Transfer control bit 1 (CPOL) sets the idle SCLK level. Bit 0 (CPHA) = 0 samples on the leading edge and drives on the trailing edge; CPHA = 1 does the reverse. All four modes move data correctly.
- R4: The burst bytes with index below the transmit count (address 4) are popped from the transmit FIFO. Every later byte, and any byte requested while the transmit FIFO is empty, goes out as 0x00.
- R5: Each shifted byte appends exactly one received byte to the receive FIFO. FIFO status bits 7:0 give the receive FIFO occupancy. Reads at address 5 return the received bytes in order.
- R6: A burst never moves more than DEPTH-1 (63) bytes. A larger burst length is cut to 63.
- R7: In the FIFO control word, bit 15 empties the receive FIFO and bit 31 empties the transmit FIFO in the same cycle. Both bits clear themselves and read back as 0.
- R8: With manual select (bit 6) set, the line picked by index bits 5:4 takes the value of level bit 7 (0 asserts it when select is active low), and the other lines stay inactive.
- R9: With manual select clear, the indexed line is asserted only while a burst runs. It is asserted low when bit 2 is 1 and high when bit 2 is 0, and at most one line is asserted at any time.
- R10: A write to transfer control during a burst is ignored. A start request while the burst length is 0 does not start a burst.
- R11: When the engine stores a received byte in the same cycle that software pops one, the receive level does not change and the popped byte is the oldest one.
- R12: The burst length and transmit count registers hold 24 bits. Write bits 31:24 are dropped on readback.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (pops the receive FIFO at address 5) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| sclk_tick | input | 1 | Half-period enable for SCLK |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 4 | Chip-select lines |

## Verification
The engine's byte push into the receive FIFO and a software pop from the same FIFO can fall in the same cycle. The bench produces this case by stopping the free-running tick and issuing ticks by hand. After the first byte has landed in the receive FIFO, it issues fifteen more ticks, then raises the final tick of the second byte together with a data read. It then checks that the byte read was the first byte, that the status level is still one, and that the next pop returns the second byte.

// File: rtl/sbx_pkg.sv
package sbx_pkg;
  localparam int CNT_W = 24;

  localparam logic [2:0] A_XCTL  = 3'd0;
  localparam logic [2:0] A_FCTL  = 3'd1;
  localparam logic [2:0] A_FSTAT = 3'd2;
  localparam logic [2:0] A_BURST = 3'd3;
  localparam logic [2:0] A_XMIT  = 3'd4;
  localparam logic [2:0] A_DATA  = 3'd5;

  localparam int FCTL_RX_CLR = 15;
  localparam int FCTL_TX_CLR = 31;

  typedef struct packed {
    logic       start;
    logic       cs_lvl;
    logic       cs_man;
    logic [1:0] cs_idx;
    logic       cs_low;
    logic       cpol;
    logic       cpha;
  } xctl_t;

  function automatic logic [31:0] xctl_pack(input xctl_t c);
    return {c.start, 23'd0, c.cs_lvl, c.cs_man, c.cs_idx, 1'b0, c.cs_low, c.cpol, c.cpha};
  endfunction

  function automatic xctl_t xctl_unpack(input logic [31:0] w);
    xctl_t c;
    c.start  = w[31];
    c.cs_lvl = w[7];
    c.cs_man = w[6];
    c.cs_idx = w[5:4];
    c.cs_low = w[2];
    c.cpol   = w[1];
    c.cpha   = w[0];
    return c;
  endfunction

  // Burst length limited so the receive FIFO cannot overflow in one burst.
  function automatic logic [CNT_W-1:0] burst_clamp(input logic [CNT_W-1:0] n,
                                                   input int unsigned lim);
    return (n > CNT_W'(lim)) ? CNT_W'(lim) : n;
  endfunction
endpackage

// File: rtl/sbx_fifo.sv
module sbx_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH):0]     level
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] cnt;
  logic          do_push, do_pop;

  assign do_push = push && (cnt != LW'(DEPTH));
  assign do_pop  = pop && (cnt != '0);
  assign dout    = mem[rp];
  assign level   = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp] <= din;
  end
endmodule

// File: rtl/sbx_shifter.sv
module sbx_shifter
  import sbx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CNT_W-1:0] len,
  input  logic [CNT_W-1:0] xmit_len,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             tick,
  input  logic             tx_avail,
  input  logic [7:0]       tx_data,
  output logic             tx_pop,
  input  logic             miso,
  output logic             rx_push,
  output logic [7:0]       rx_data,
  output logic             busy,
  output logic             last_done,
  output logic             sclk,
  output logic             mosi
);
  logic [3:0]       half;
  logic [CNT_W-1:0] idx, nbytes;
  logic [7:0]       tx_sh, rx_sh;
  logic             sclk_q, mosi_q, busy_q;

  logic             edge_ev, leading, sample_ev, drive_ev, byte_done, need_load, use_fifo;
  logic [CNT_W-1:0] load_idx;
  logic [7:0]       rx_next, load_byte;

  assign edge_ev   = busy_q & tick;
  assign leading   = ~half[0];
  assign sample_ev = edge_ev & (leading ^ cpha);
  assign drive_ev  = edge_ev & ~(leading ^ cpha) & (half != 4'd15);
  assign byte_done = edge_ev & (half == 4'd15);
  assign last_done = byte_done & (idx == nbytes - 1'b1);
  assign rx_next   = {rx_sh[6:0], miso};

  assign need_load = go | (byte_done & ~last_done);
  assign load_idx  = go ? '0 : idx + 1'b1;
  assign use_fifo  = (load_idx < xmit_len) & tx_avail;
  assign tx_pop    = need_load & use_fifo;
  assign load_byte = use_fifo ? tx_data : 8'h00;

  assign rx_push = byte_done;
  assign rx_data = cpha ? rx_next : rx_sh;
  assign busy    = busy_q;
  assign sclk    = busy_q ? sclk_q : cpol;
  assign mosi    = mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half   <= '0;
      idx    <= '0;
      nbytes <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
      busy_q <= 1'b0;
    end else if (go) begin
      busy_q <= 1'b1;
      half   <= '0;
      idx    <= '0;
      nbytes <= len;
      rx_sh  <= '0;
      sclk_q <= cpol;
      if (cpha) begin
        tx_sh <= load_byte;
      end else begin
        mosi_q <= load_byte[7];
        tx_sh  <= {load_byte[6:0], 1'b0};
      end
    end else if (edge_ev) begin
      sclk_q <= ~sclk_q;
      half   <= half + 1'b1;
      if (sample_ev) rx_sh <= rx_next;
      if (drive_ev) begin
        mosi_q <= tx_sh[7];
        tx_sh  <= {tx_sh[6:0], 1'b0};
      end
      if (byte_done) begin
        idx <= idx + 1'b1;
        if (last_done) begin
          busy_q <= 1'b0;
        end else if (cpha) begin
          tx_sh <= load_byte;
        end else begin
          mosi_q <= load_byte[7];
          tx_sh  <= {load_byte[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/sbx_csgen.sv
module sbx_csgen #(
  parameter int NCS = 4
) (
  input  logic                   busy,
  input  logic                   man,
  input  logic                   lvl,
  input  logic                   low,
  input  logic [$clog2(NCS)-1:0] sel_idx,
  output logic [NCS-1:0]         cs
);
  localparam int IW = $clog2(NCS);

  for (genvar i = 0; i < NCS; i++) begin : g_line
    logic picked;
    assign picked = (sel_idx == IW'(i));
    assign cs[i]  = !picked ? low : (man ? lvl : (busy ? ~low : low));
  end
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import sbx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int NCS   = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     reg_addr,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic           sclk_tick,
  output logic           spi_sclk,
  output logic           spi_mosi,
  input  logic           spi_miso,
  output logic [NCS-1:0] spi_cs
);
  localparam int LW = $clog2(DEPTH) + 1;
  localparam int IW = $clog2(NCS);

  xctl_t            ctl_q, ctl_rd, ctl_wr;
  logic [CNT_W-1:0] burst_q, xmit_q, eff_len;
  logic             busy_w, last_done_w, go_w;
  logic             rx_push_w, rx_pop_w, rx_clr_w, tx_clr_w, tx_push_w, tx_pop_w;
  logic [LW-1:0]    rx_level_w, tx_level_w;
  logic [7:0]       rx_byte_w, rx_head_w, tx_head_w;
  logic             unused_bits;

  assign unused_bits = ^reg_wdata[30:24];
  assign ctl_wr      = xctl_unpack(reg_wdata);
  assign eff_len     = burst_clamp(burst_q, DEPTH - 1);
  assign go_w        = reg_wr && (reg_addr == A_XCTL) && !busy_w && ctl_wr.start && (eff_len != '0);
  assign rx_clr_w    = reg_wr && (reg_addr == A_FCTL) && reg_wdata[FCTL_RX_CLR];
  assign tx_clr_w    = reg_wr && (reg_addr == A_FCTL) && reg_wdata[FCTL_TX_CLR];
  assign tx_push_w   = reg_wr && (reg_addr == A_DATA);
  assign rx_pop_w    = reg_rd && (reg_addr == A_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q        <= '0;
      ctl_q.cs_low <= 1'b1;
      burst_q      <= '0;
      xmit_q       <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_XCTL && !busy_w) begin
        ctl_q       <= ctl_wr;
        ctl_q.start <= 1'b0;
      end
      if (reg_addr == A_BURST) burst_q <= reg_wdata[CNT_W-1:0];
      if (reg_addr == A_XMIT)  xmit_q  <= reg_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    ctl_rd       = ctl_q;
    ctl_rd.start = busy_w;
    case (reg_addr)
      A_XCTL:  reg_rdata = xctl_pack(ctl_rd);
      A_FSTAT: reg_rdata = {{(32-LW){1'b0}}, rx_level_w};
      A_BURST: reg_rdata = {{(32-CNT_W){1'b0}}, burst_q};
      A_XMIT:  reg_rdata = {{(32-CNT_W){1'b0}}, xmit_q};
      A_DATA:  reg_rdata = {24'd0, rx_head_w};
      default: reg_rdata = '0;
    endcase
  end

  sbx_fifo #(.DEPTH(DEPTH), .W(8)) u_txf (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr_w), .push(tx_push_w), .din(reg_wdata[7:0]),
    .pop(tx_pop_w), .dout(tx_head_w), .level(tx_level_w)
  );

  sbx_fifo #(.DEPTH(DEPTH), .W(8)) u_rxf (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr_w), .push(rx_push_w), .din(rx_byte_w),
    .pop(rx_pop_w), .dout(rx_head_w), .level(rx_level_w)
  );

  sbx_shifter u_eng (
    .clk(clk), .rst_n(rst_n), .go(go_w), .len(eff_len), .xmit_len(xmit_q),
    .cpol(ctl_q.cpol), .cpha(ctl_q.cpha), .tick(sclk_tick),
    .tx_avail(tx_level_w != '0), .tx_data(tx_head_w), .tx_pop(tx_pop_w),
    .miso(spi_miso), .rx_push(rx_push_w), .rx_data(rx_byte_w),
    .busy(busy_w), .last_done(last_done_w), .sclk(spi_sclk), .mosi(spi_mosi)
  );

  sbx_csgen #(.NCS(NCS)) u_cs (
    .busy(busy_w), .man(ctl_q.cs_man), .lvl(ctl_q.cs_lvl), .low(ctl_q.cs_low),
    .sel_idx(ctl_q.cs_idx[IW-1:0]), .cs(spi_cs)
  );
endmodule

// File: rtl/sbx_checker.sv
module sbx_checker #(
  parameter int DEPTH = 64,
  parameter int NCS   = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   busy,
  input logic                   last_done,
  input logic                   rx_push,
  input logic                   rx_pop,
  input logic                   rx_clr,
  input logic                   tx_clr,
  input logic [$clog2(DEPTH):0] rx_level,
  input logic [$clog2(DEPTH):0] tx_level,
  input logic                   sclk,
  input logic                   cpol,
  input logic                   cs_man,
  input logic                   cs_low,
  input logic [NCS-1:0]         cs
);
  localparam int LW = $clog2(DEPTH) + 1;

  logic [NCS-1:0] cs_act;
  assign cs_act = cs ^ {NCS{cs_low}};

  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(last_done));

  // R3
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (sclk == cpol));

  // R5
  rx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !rx_pop && !rx_clr && (rx_level < LW'(DEPTH))) |=> (rx_level == $past(rx_level) + 1'b1));

  // R11
  same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_pop && !rx_clr && (rx_level != '0)) |=> (rx_level == $past(rx_level)));

  // R7
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |=> (rx_level == '0));

  // R7
  tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clr |=> (tx_level == '0));

  // R8
  cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_act));

  // R9
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_man && !busy) |-> (cs_act == '0));
endmodule

bind spi_burst_master sbx_checker #(.DEPTH(DEPTH), .NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_w), .last_done(last_done_w),
  .rx_push(rx_push_w), .rx_pop(rx_pop_w), .rx_clr(rx_clr_w), .tx_clr(tx_clr_w),
  .rx_level(rx_level_w), .tx_level(tx_level_w), .sclk(spi_sclk), .cpol(ctl_q.cpol),
  .cs_man(ctl_q.cs_man), .cs_low(ctl_q.cs_low), .cs(spi_cs)
);

// File: tb/sim_spi_burst_master.sv
module sim_spi_burst_master;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_XCTL = 3'd0, A_FCTL = 3'd1, A_FSTAT = 3'd2,
                         A_BURST = 3'd3, A_XMIT = 3'd4, A_DATA = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        sclk_tick, spi_sclk, spi_mosi, spi_miso;
  logic [3:0]  spi_cs;
  logic        auto_tick = 1'b1, man_tick = 1'b0, div_q = 1'b0, miso_inv = 1'b0;

  int n_chk = 0, n_fail = 0;
  logic [7:0] mosi_q[$];
  logic [7:0] stage_q[$];
  logic       mon_on = 1'b0, m_cpol = 1'b0, m_cpha = 1'b0, m_prev = 1'b0;
  logic [7:0] m_byte = '0;
  int         m_bits = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) div_q <= ~div_q;
  assign sclk_tick = auto_tick ? div_q : man_tick;
  assign spi_miso  = spi_mosi ^ miso_inv;

  spi_burst_master u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk_tick(sclk_tick),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs(spi_cs)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: rebuilds MOSI bytes on the sampling edge and pops the scoreboard.
  always @(negedge clk) begin
    if (!mon_on) begin
      m_bits = 0;
    end else if (spi_sclk !== m_prev) begin
      if ((m_prev == m_cpol) ^ m_cpha) begin
        m_byte = {m_byte[6:0], spi_mosi};
        m_bits++;
        if (m_bits == 8) begin
          m_bits = 0;
          if (mosi_q.size() == 0) chk(1'b0, "R2 unexpected byte", {24'd0, m_byte}, 32'd0);
          else begin
            logic [7:0] e;
            e = mosi_q.pop_front();
            chk(m_byte == e, "R2/R3 mosi byte", {24'd0, m_byte}, {24'd0, e});
          end
        end
      end
    end
    m_prev = spi_sclk;
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_level(input int n);
    logic [31:0] v;
    for (int g = 0; g < 6000; g++) begin
      rd(A_FSTAT, v);
      if (v[7:0] == n[7:0]) break;
    end
  endtask

  // Driver: queues expected bytes, starts a burst, then checks the received data.
  task automatic run_burst(input int xmit, input int burst, input logic [1:0] mode, input string req);
    logic [31:0] v;
    logic [7:0]  exp_tx[$];
    int eff;
    eff = (burst > 63) ? 63 : burst;
    foreach (stage_q[k]) wr(A_DATA, {24'd0, stage_q[k]});
    for (int k = 0; k < eff; k++)
      exp_tx.push_back((k < xmit && k < stage_q.size()) ? stage_q[k] : 8'h00);
    wr(A_BURST, burst);
    wr(A_XMIT, xmit);
    wr(A_XCTL, {29'd0, 1'b1, mode});
    m_cpol = mode[1]; m_cpha = mode[0];
    @(negedge clk);
    chk(spi_sclk == mode[1], "R3 idle sclk", {31'd0, spi_sclk}, {31'd0, mode[1]});
    foreach (exp_tx[k]) mosi_q.push_back(exp_tx[k]);
    mon_on = 1'b1;
    wr(A_XCTL, {1'b1, 28'd0, 1'b1, mode});
    chk(spi_cs == 4'hE, "R9 auto select during burst", {28'd0, spi_cs}, 32'hE);
    rd(A_XCTL, v);
    chk(v[31] == 1'b1, "R2 start reads 1", v, 32'h8000_0000);
    wait_level(eff);
    rd(A_XCTL, v);
    chk(v == {29'd0, 1'b1, mode}, "R2 start cleared", v, {29'd0, 1'b1, mode});
    chk(spi_cs == 4'hF, "R9 select released", {28'd0, spi_cs}, 32'hF);
    rd(A_FSTAT, v);
    chk(v == eff, {req, " rx level"}, v, eff);
    chk(mosi_q.size() == 0, "R2 all bytes shifted", mosi_q.size(), 0);
    mon_on = 1'b0;
    foreach (exp_tx[k]) begin
      rd(A_DATA, v);
      chk(v[7:0] == (exp_tx[k] ^ {8{miso_inv}}), "R5 rx byte", v, {24'd0, exp_tx[k] ^ {8{miso_inv}}});
    end
    stage_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    chk(spi_sclk == 1'b0, "R1 sclk reset", {31'd0, spi_sclk}, 0);
    chk(spi_cs == 4'hF, "R1 cs reset", {28'd0, spi_cs}, 32'hF);
    rst_n = 1'b1;
    @(negedge clk);
    rd(A_XCTL, v);  chk(v == 32'h4, "R1 control reset", v, 32'h4);
    rd(A_FSTAT, v); chk(v == 32'h0, "R1 status reset", v, 0);

    // R12 counter widths
    wr(A_BURST, 32'hAB00_0005); rd(A_BURST, v); chk(v == 32'h5, "R12 burst width", v, 32'h5);
    wr(A_XMIT, 32'hFF12_3456);  rd(A_XMIT, v);  chk(v == 32'h12_3456, "R12 xmit width", v, 32'h12_3456);

    // R2/R3 all four modes
    stage_q = '{8'hA5, 8'h3C, 8'h01, 8'hFF};
    run_burst(4, 4, 2'b00, "R2 mode0");
    miso_inv = 1'b1;
    stage_q = '{8'h81, 8'h7E, 8'h5A};
    run_burst(3, 3, 2'b01, "R3 mode1");
    stage_q = '{8'hC3, 8'h12};
    run_burst(2, 2, 2'b10, "R3 mode2");
    stage_q = '{8'h96, 8'h69, 8'hF0};
    run_burst(3, 3, 2'b11, "R3 mode3");
    miso_inv = 1'b0;

    // R4 transmit count and empty FIFO give zeros
    stage_q = '{8'h11, 8'h22};
    run_burst(2, 4, 2'b00, "R4 xmit count");
    stage_q = '{8'h33};
    run_burst(4, 3, 2'b00, "R4 empty fifo");

    // R7 transmit FIFO reset, then receive FIFO reset
    wr(A_DATA, 32'h77); wr(A_DATA, 32'h88);
    wr(A_FCTL, 32'h8000_0000);
    rd(A_FCTL, v); chk(v == 0, "R7 fifo ctl self clear", v, 0);
    run_burst(2, 2, 2'b00, "R7 tx cleared");
    mon_on = 1'b0;
    wr(A_XCTL, 32'h4);
    mosi_q.push_back(8'h00);
    mon_on = 1'b1;
    wr(A_BURST, 1); wr(A_XCTL, 32'h8000_0004);
    wait_level(1);
    mon_on = 1'b0;
    wr(A_FCTL, 32'h0000_8000);
    rd(A_FSTAT, v); chk(v == 0, "R7 rx cleared", v, 0);

    // R6 burst clamped to 63
    run_burst(0, 100, 2'b00, "R6 clamp");

    // R8 manual select
    wr(A_XCTL, 32'h0000_0064); @(negedge clk);
    chk(spi_cs == 4'hB, "R8 manual assert low", {28'd0, spi_cs}, 32'hB);
    wr(A_XCTL, 32'h0000_00E4); @(negedge clk);
    chk(spi_cs == 4'hF, "R8 manual release", {28'd0, spi_cs}, 32'hF);
    wr(A_XCTL, 32'h0000_00D0); @(negedge clk);
    chk(spi_cs == 4'h2, "R8 manual active high", {28'd0, spi_cs}, 32'h2);
    wr(A_XCTL, 32'h0000_0004); @(negedge clk);

    // R10 write during burst ignored, zero-length start ignored
    m_cpol = 1'b0; m_cpha = 1'b0;
    mosi_q.push_back(8'h00); mosi_q.push_back(8'h00);
    mon_on = 1'b1;
    wr(A_BURST, 2); wr(A_XMIT, 0);
    wr(A_XCTL, 32'h8000_0004);
    wr(A_XCTL, 32'h0000_00F7);
    rd(A_XCTL, v); chk(v == 32'h8000_0004, "R10 control locked while busy", v, 32'h8000_0004);
    wait_level(2);
    mon_on = 1'b0;
    rd(A_XCTL, v); chk(v == 32'h4, "R10 control after burst", v, 32'h4);
    wr(A_FCTL, 32'h0000_8000);
    wr(A_BURST, 0); wr(A_XCTL, 32'h8000_0004);
    rd(A_XCTL, v); chk(v == 32'h4, "R10 zero burst no start", v, 32'h4);
    rd(A_FSTAT, v); chk(v == 0, "R10 zero burst no data", v, 0);

    // R11 push and pop in one cycle, hand-driven ticks
    auto_tick = 1'b0;
    wr(A_DATA, 32'hAA); wr(A_DATA, 32'h55);
    wr(A_BURST, 2); wr(A_XMIT, 2);
    mosi_q.push_back(8'hAA); mosi_q.push_back(8'h55);
    mon_on = 1'b1;
    wr(A_XCTL, 32'h8000_0004);
    for (int t = 0; t < 31; t++) begin
      man_tick = 1'b1; @(negedge clk);
      man_tick = 1'b0; @(negedge clk);
      if (t == 15) begin
        rd(A_FSTAT, v); chk(v == 1, "R5 level after first byte", v, 1);
      end
    end
    man_tick = 1'b1; reg_addr = A_DATA; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    man_tick = 1'b0; reg_rd = 1'b0;
    chk(v[7:0] == 8'hAA, "R11 popped oldest", v, 32'hAA);
    rd(A_FSTAT, v); chk(v == 1, "R11 level unchanged", v, 1);
    rd(A_DATA, v);  chk(v[7:0] == 8'h55, "R11 second byte", v, 32'h55);
    rd(A_XCTL, v);  chk(v[31] == 1'b0, "R11 burst finished", v, 32'h4);
    mon_on = 1'b0;
    auto_tick = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule